// File: doc/BRIEF.md
# DMA Peripheral Trigger and Flag Handshake Unit

This unit turns peripheral status flags into requests for a single DMA channel. A select input picks one of four sources: a serial transmitter's ready flag, an ADC result-ready flag array, a DAC data-request flag, or a flash-ready condition. A rising edge on the selected trigger raises `dma_req_o`. The request stays high until the DMA engine acknowledges the transfer. In the acknowledge cycle the unit pulses a clear strobe back to the source whose flag caused the request, so software never has to clear that flag.

The trigger is qualified in two ways. When the transmitter's interrupt enable is set, its ready flag does not trigger a transfer. For the ADC, the sequence mode decides which result flag counts. In the single-slot modes it is the flag of the slot the converter is working on. In the multi-slot modes it is only the flag of the last slot of the sequence. For flash writes the unit checks at acknowledge time that the flash controller is armed and idle, and raises a fail indicator when it is not.

Top module: `dma_trig_hs`

## Requirements
- R1: With `trig_sel_i`=0 (serial transmit) and `tx_ie_i` low, a rising edge of `tx_ready_i` sets `dma_req_o` after the next clock edge.
- R2: With `trig_sel_i`=0 and `tx_ie_i` high, `tx_ready_i` never raises `dma_req_o`.
- R3: When `dma_ack_i` is high while a transmit request is pending, `tx_flag_clr_o` is high in that same cycle.
- R4: With `trig_sel_i`=1 (ADC), when `adc_seq_mode_i` is 0 or 2 (bit 0 clear) the trigger is `adc_flags_i[adc_cur_slot_i]`. When it is 1 or 3 (bit 0 set) the trigger is only `adc_flags_i[adc_last_slot_i]`.
- R5: Acknowledging an ADC request pulses exactly one bit of `adc_flag_clr_o` in the acknowledge cycle. That bit is the qualifying slot captured when the request was raised, even if the slot inputs have changed since.
- R6: With `trig_sel_i`=2 (DAC), a rising `dac_req_i` raises `dma_req_o`, and the acknowledge pulses `dac_flag_clr_o`.
- R7: With `trig_sel_i`=3 (flash), a rising edge of (`flash_armed_i` and not `flash_busy_i`) raises a request. If the flash is not armed, or is busy, in the acknowledge cycle, `flash_fail_o` is 1 from the next cycle on. A successful flash acknowledge clears it.
- R8: Each trigger rising edge gives at most one request. `dma_req_o` holds until acknowledged and drops after the acknowledge cycle. Edges that arrive while a request is pending are dropped.
- R9: Select values 4 to 7 never raise `dma_req_o`.
- R10: Reset (`rst_ni` low) forces `dma_req_o` and `flash_fail_o` to 0.
- R11: `dma_ack_i` with no request pending produces no clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_sel_i | input | 3 | Trigger source select (0 tx, 1 ADC, 2 DAC, 3 flash) |
| tx_ready_i | input | 1 | Serial transmit-ready flag |
| tx_ie_i | input | 1 | Serial transmit interrupt enable |
| tx_flag_clr_o | output | 1 | Clear strobe for the transmit-ready flag |
| adc_flags_i | input | ADC_SLOTS | ADC per-slot result-ready flags |
| adc_seq_mode_i | input | 2 | ADC sequence mode |
| adc_cur_slot_i | input | IDX_W | Slot the converter is currently using |
| adc_last_slot_i | input | IDX_W | Last slot of the conversion sequence |
| adc_flag_clr_o | output | ADC_SLOTS | Per-slot clear strobes for the ADC flags |
| dac_req_i | input | 1 | DAC data-request flag |
| dac_flag_clr_o | output | 1 | Clear strobe for the DAC flag |
| flash_armed_i | input | 1 | Flash controller set up for writes |
| flash_busy_i | input | 1 | Flash controller busy |
| flash_fail_o | output | 1 | Last flash transfer failed |
| dma_req_o | output | 1 | DMA request |
| dma_ack_i | input | 1 | DMA acknowledge / data access |

## Verification
Randomized ADC trials choose the mode, current slot, last slot and flags, then move the slot inputs before the acknowledge. A design that checks the wrong slot in some mode, or decodes the clear from the live inputs, strobes the wrong flag. The bench sends a second DAC edge while a request is pending. A level-triggered or queuing design would then issue an extra request. Flash trials make the flash go busy between request and acknowledge, then check that the fail flag sets and later clears, which catches a design that checks readiness only at trigger time. Randomized transmit trials with the interrupt enable set catch a missing enable gate.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_TX    = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADC   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_DAC   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_FLASH = 3'd3;
endpackage

// File: rtl/dma_trig_src_mux.sv
module dma_trig_src_mux
  import dma_trig_pkg::*;
#(
  parameter int ADC_SLOTS = 16,
  parameter int IDX_W     = $clog2(ADC_SLOTS)
) (
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 tx_ready_i,
  input  logic                 tx_ie_i,
  input  logic [ADC_SLOTS-1:0] adc_flags_i,
  input  logic [1:0]           adc_seq_mode_i,
  input  logic [IDX_W-1:0]     adc_cur_slot_i,
  input  logic [IDX_W-1:0]     adc_last_slot_i,
  input  logic                 dac_req_i,
  input  logic                 flash_armed_i,
  input  logic                 flash_busy_i,
  output logic                 trig_o,
  output logic [IDX_W-1:0]     slot_o
);
  logic adc_lvl;

  // multi-slot modes qualify only on the last slot
  assign slot_o  = adc_seq_mode_i[0] ? adc_last_slot_i : adc_cur_slot_i;
  assign adc_lvl = (int'(slot_o) < ADC_SLOTS) ? adc_flags_i[slot_o] : 1'b0;

  always_comb begin
    unique case (sel_i)
      SEL_TX:    trig_o = tx_ready_i & ~tx_ie_i;
      SEL_ADC:   trig_o = adc_lvl;
      SEL_DAC:   trig_o = dac_req_i;
      SEL_FLASH: trig_o = flash_armed_i & ~flash_busy_i;
      default:   trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_trig_edge_req.sv
module dma_trig_edge_req
  import dma_trig_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [IDX_W-1:0] slot_i,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [SEL_W-1:0] sel_q_o,
  output logic [IDX_W-1:0] slot_q_o
);
  logic trig_q;
  logic rise;

  assign rise = trig_i & ~trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q   <= 1'b0;
      pend_o   <= 1'b0;
      sel_q_o  <= '0;
      slot_q_o <= '0;
    end else begin
      trig_q <= trig_i;
      if (pend_o) begin
        if (ack_i) pend_o <= 1'b0;       // edges while pending are dropped
      end else if (rise) begin
        pend_o   <= 1'b1;
        sel_q_o  <= sel_i;
        slot_q_o <= slot_i;
      end
    end
  end
endmodule

// File: rtl/dma_trig_clear_gen.sv
module dma_trig_clear_gen
  import dma_trig_pkg::*;
#(
  parameter int ADC_SLOTS = 16,
  parameter int IDX_W     = $clog2(ADC_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pend_i,
  input  logic                 ack_i,
  input  logic [SEL_W-1:0]     sel_q_i,
  input  logic [IDX_W-1:0]     slot_q_i,
  input  logic                 flash_armed_i,
  input  logic                 flash_busy_i,
  output logic                 tx_clr_o,
  output logic                 dac_clr_o,
  output logic [ADC_SLOTS-1:0] adc_clr_o,
  output logic                 flash_fail_o
);
  logic done;
  logic flash_done;

  assign done       = pend_i & ack_i;
  assign tx_clr_o   = done & (sel_q_i == SEL_TX);
  assign dac_clr_o  = done & (sel_q_i == SEL_DAC);
  assign flash_done = done & (sel_q_i == SEL_FLASH);

  for (genvar g = 0; g < ADC_SLOTS; g++) begin : g_adc_clr
    assign adc_clr_o[g] = done & (sel_q_i == SEL_ADC) & (int'(slot_q_i) == g);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flash_fail_o <= 1'b0;
    else if (flash_done) flash_fail_o <= ~flash_armed_i | flash_busy_i;
  end
endmodule

// File: rtl/dma_trig_hs.sv
module dma_trig_hs
  import dma_trig_pkg::*;
#(
  parameter int ADC_SLOTS = 16,
  parameter int IDX_W     = $clog2(ADC_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           trig_sel_i,
  input  logic                 tx_ready_i,
  input  logic                 tx_ie_i,
  output logic                 tx_flag_clr_o,
  input  logic [ADC_SLOTS-1:0] adc_flags_i,
  input  logic [1:0]           adc_seq_mode_i,
  input  logic [IDX_W-1:0]     adc_cur_slot_i,
  input  logic [IDX_W-1:0]     adc_last_slot_i,
  output logic [ADC_SLOTS-1:0] adc_flag_clr_o,
  input  logic                 dac_req_i,
  output logic                 dac_flag_clr_o,
  input  logic                 flash_armed_i,
  input  logic                 flash_busy_i,
  output logic                 flash_fail_o,
  output logic                 dma_req_o,
  input  logic                 dma_ack_i
);
  logic             trig;
  logic [IDX_W-1:0] slot;
  logic [SEL_W-1:0] sel_q;
  logic [IDX_W-1:0] slot_q;

  dma_trig_src_mux #(.ADC_SLOTS(ADC_SLOTS), .IDX_W(IDX_W)) u_mux (
    .sel_i          (trig_sel_i),
    .tx_ready_i     (tx_ready_i),
    .tx_ie_i        (tx_ie_i),
    .adc_flags_i    (adc_flags_i),
    .adc_seq_mode_i (adc_seq_mode_i),
    .adc_cur_slot_i (adc_cur_slot_i),
    .adc_last_slot_i(adc_last_slot_i),
    .dac_req_i      (dac_req_i),
    .flash_armed_i  (flash_armed_i),
    .flash_busy_i   (flash_busy_i),
    .trig_o         (trig),
    .slot_o         (slot)
  );

  dma_trig_edge_req #(.IDX_W(IDX_W)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig),
    .sel_i   (trig_sel_i),
    .slot_i  (slot),
    .ack_i   (dma_ack_i),
    .pend_o  (dma_req_o),
    .sel_q_o (sel_q),
    .slot_q_o(slot_q)
  );

  dma_trig_clear_gen #(.ADC_SLOTS(ADC_SLOTS), .IDX_W(IDX_W)) u_clr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_i       (dma_req_o),
    .ack_i        (dma_ack_i),
    .sel_q_i      (sel_q),
    .slot_q_i     (slot_q),
    .flash_armed_i(flash_armed_i),
    .flash_busy_i (flash_busy_i),
    .tx_clr_o     (tx_flag_clr_o),
    .dac_clr_o    (dac_flag_clr_o),
    .adc_clr_o    (adc_flag_clr_o),
    .flash_fail_o (flash_fail_o)
  );
endmodule

// File: rtl/dma_trig_hs_chk.sv
module dma_trig_hs_chk #(
  parameter int ADC_SLOTS = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           trig_sel_i,
  input logic                 tx_ie_i,
  input logic                 tx_flag_clr_o,
  input logic [ADC_SLOTS-1:0] adc_flag_clr_o,
  input logic                 dac_flag_clr_o,
  input logic                 flash_fail_o,
  input logic                 dma_req_o,
  input logic                 dma_ack_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && !dma_ack_i |=> dma_req_o); // R8
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && dma_ack_i |=> !dma_req_o); // R8
  AST_TX_IE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_req_o && trig_sel_i == 3'd0 && tx_ie_i |=> !dma_req_o); // R2
  AST_BAD_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_req_o && trig_sel_i[2] |=> !dma_req_o); // R9
  AST_ADC_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(adc_flag_clr_o)); // R5
  AST_CLR_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_flag_clr_o || dac_flag_clr_o || (|adc_flag_clr_o)) |-> dma_req_o && dma_ack_i); // R11
  AST_FAIL_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_fail_o && !(dma_req_o && dma_ack_i) |=> !flash_fail_o); // R7
endmodule

bind dma_trig_hs dma_trig_hs_chk #(.ADC_SLOTS(ADC_SLOTS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trig_sel_i    (trig_sel_i),
  .tx_ie_i       (tx_ie_i),
  .tx_flag_clr_o (tx_flag_clr_o),
  .adc_flag_clr_o(adc_flag_clr_o),
  .dac_flag_clr_o(dac_flag_clr_o),
  .flash_fail_o  (flash_fail_o),
  .dma_req_o     (dma_req_o),
  .dma_ack_i     (dma_ack_i)
);

// File: tb/dma_trig_hs_test.sv
module dma_trig_hs_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 16;
  localparam int IW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      sel = 3'd7;
  logic            tx_ready = 1'b0, tx_ie = 1'b0, tx_clr;
  logic [SLOTS-1:0] adc_flags = '0, adc_clr;
  logic [1:0]      adc_mode = 2'd0;
  logic [IW-1:0]   cur_slot = '0, last_slot = '0;
  logic            dac_req = 1'b0, dac_clr;
  logic            armed = 1'b0, busy = 1'b0, fail;
  logic            req, ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int unsigned seed_v;

  dma_trig_hs #(.ADC_SLOTS(SLOTS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .trig_sel_i(sel),
    .tx_ready_i(tx_ready), .tx_ie_i(tx_ie), .tx_flag_clr_o(tx_clr),
    .adc_flags_i(adc_flags), .adc_seq_mode_i(adc_mode),
    .adc_cur_slot_i(cur_slot), .adc_last_slot_i(last_slot), .adc_flag_clr_o(adc_clr),
    .dac_req_i(dac_req), .dac_flag_clr_o(dac_clr),
    .flash_armed_i(armed), .flash_busy_i(busy), .flash_fail_o(fail),
    .dma_req_o(req), .dma_ack_i(ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [IW-1:0] exp_slot(logic [1:0] m, logic [IW-1:0] c, logic [IW-1:0] l);
    return m[0] ? l : c;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // one clock edge, then settle to a quarter period after it
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic ack_cycle();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    seed_v = $urandom(32'h5eed_1234);
    step(); step();
    chk("R10 req in reset", {31'd0, req}, 0);
    chk("R10 fail in reset", {31'd0, fail}, 0);
    rst_n = 1'b1;
    step();

    // R1 / R3 / R8 transmit path
    sel = 3'd0; tx_ready = 1'b1; step();
    chk("R1 tx request", {31'd0, req}, 1);
    step();
    chk("R8 request held", {31'd0, req}, 1);
    ack = 1'b1; #1;
    chk("R3 tx clear", {31'd0, tx_clr}, 1);
    chk("R11 no dac clear on tx", {31'd0, dac_clr}, 0);
    step(); ack = 1'b0; tx_ready = 1'b0;
    chk("R8 request drops after ack", {31'd0, req}, 0);
    step();

    // R2 interrupt enable gate
    tx_ie = 1'b1; tx_ready = 1'b1; step(); step();
    chk("R2 ie blocks request", {31'd0, req}, 0);
    tx_ready = 1'b0; tx_ie = 1'b0; step();

    // R6 / R8 dac with extra edge while pending
    sel = 3'd2; dac_req = 1'b1; step();
    chk("R6 dac request", {31'd0, req}, 1);
    dac_req = 1'b0; step(); dac_req = 1'b1; step();
    ack = 1'b1; #1;
    chk("R6 dac clear", {31'd0, dac_clr}, 1);
    step(); ack = 1'b0; step();
    chk("R8 edge while pending dropped", {31'd0, req}, 0);
    dac_req = 1'b0; step();

    // R9 / R11
    sel = 3'd5;
    for (int i = 0; i < 4; i++) begin
      tx_ready = ~tx_ready; dac_req = ~dac_req; adc_flags = ~adc_flags; step();
    end
    chk("R9 unused select", {31'd0, req}, 0);
    ack = 1'b1; #1;
    chk("R11 ack idle no clear", {tx_clr, dac_clr, 14'd0, adc_clr}, 0);
    step(); ack = 1'b0;
    tx_ready = 1'b0; dac_req = 1'b0; adc_flags = '0; step();

    // R4 / R5 randomized ADC trials
    sel = 3'd1;
    for (int i = 0; i < 60; i++) begin
      logic [IW-1:0] q;
      logic [SLOTS-1:0] fl;
      logic hit;
      adc_flags = '0; step();
      adc_mode  = 2'($urandom());
      cur_slot  = IW'($urandom());
      last_slot = IW'($urandom());
      fl = SLOTS'($urandom());
      q = exp_slot(adc_mode, cur_slot, last_slot);
      if (i < 4) fl = 16'(1) << (i[0] ? cur_slot : last_slot);
      adc_flags = fl;
      hit = fl[q];
      step();
      chk($sformatf("R4 adc qualify mode %0d", adc_mode), {31'd0, req}, {31'd0, hit});
      if (req) begin
        cur_slot = IW'($urandom()); last_slot = IW'($urandom());
        ack = 1'b1; #1;
        chk("R5 adc clear slot", {16'd0, adc_clr}, {16'd0, 16'(1) << q});
        step(); ack = 1'b0;
      end
    end
    adc_flags = '0; step(); step();

    // R7 flash
    sel = 3'd3; armed = 1'b1; step();
    chk("R7 flash request", {31'd0, req}, 1);
    ack_cycle();
    chk("R7 flash ok", {31'd0, fail}, 0);
    armed = 1'b0; step(); armed = 1'b1; step();
    chk("R7 flash second request", {31'd0, req}, 1);
    busy = 1'b1; ack_cycle();
    chk("R7 busy gives fail", {31'd0, fail}, 1);
    step();
    chk("R7 fail sticky", {31'd0, fail}, 1);
    busy = 1'b0; step();
    chk("R7 ready again requests", {31'd0, req}, 1);
    ack_cycle();
    chk("R7 success clears fail", {31'd0, fail}, 0);
    armed = 1'b0; step(); armed = 1'b1; step(); armed = 1'b0; ack_cycle();
    chk("R7 unarmed gives fail", {31'd0, fail}, 1);
    rst_n = 1'b0; step();
    chk("R10 reset clears fail", {31'd0, fail}, 0);
    rst_n = 1'b1; step();

    // R1 / R2 randomized transmit trials
    sel = 3'd0;
    for (int i = 0; i < 40; i++) begin
      logic ie;
      ie = 1'($urandom());
      tx_ie = ie; tx_ready = 1'b1; step();
      chk(ie ? "R2 random ie" : "R1 random tx", {31'd0, req}, {31'd0, ~ie});
      if (req) begin
        ack = 1'b1; #1;
        chk("R3 random tx clear", {31'd0, tx_clr}, 1);
        step(); ack = 1'b0;
      end
      tx_ready = 1'b0; step();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule